// File: doc/BRIEF.md
# External Interrupt Line Controller

This block takes up to four interrupt pins from outside the chip and turns each one into a conditioned interrupt request for a parent interrupt controller. Every pin is brought into the clock domain through a two-stage synchroniser. It is then judged as a level, a single edge or either edge, as its trigger settings select. A hit sets a per-line pending bit. Each request output is that pending bit gated by the line's enable.

Software sees one 32-bit word holding six per-line fields. Each field is as wide as a build-time stride of 4 or 5 bits, so one design serves both register layouts. The word is written with a single-cycle write strobe and is read back combinationally. Configuration fields take the written value. The pending field cannot be written. The acknowledge field is a write-one pulse and is never stored. There is no streaming data path, so the register port is a plain strobe with no back-pressure.

Top module: `extirq_ctrl`

## Requirements
- R1: Field k occupies bits k*STRIDE up to k*STRIDE+NUM_LINES-1, and line n sits at bit n of each field. The field indices are: 0 sense, 1 pending, 2 acknowledge, 3 enable, 4 any-edge, 5 level-mode. Bits for lines at or above NUM_LINES, and bits at or above 6*STRIDE, read 0 and ignore writes.
- R2: After reset, each line has level-mode=1, sense=0 (active-low level), any-edge=0 and enable=0. With the pins held high, the word reads only the level-mode bits and every request output is 0.
- R3: In level mode, the pending bit equals (synchronised pin == sense). A pin change shows in the pending bit on the third rising clock edge after it, and not on the second. An acknowledge does not clear the bit while the pin stays active.
- R4: With level-mode=0, any-edge=0 and sense=0, a rising pin edge sets the pending bit and a falling edge does not. The bit then stays set after the pin returns.
- R5: With level-mode=0, any-edge=0 and sense=1, a falling pin edge sets the pending bit and a rising edge does not.
- R6: With level-mode=0 and any-edge=1, both rising and falling pin edges set the pending bit.
- R7: In an edge mode, writing 1 to the line's acknowledge bit clears its pending bit on that write's clock edge, and writing 0 leaves it set. The acknowledge field always reads 0. If a new edge is detected on the same clock edge as an acknowledge, the pending bit stays set.
- R8: Each request output is the line's pending bit AND its enable bit. The pending bit stays readable while the enable bit is 0.
- R9: Writes to the pending field have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | NUM_LINES | Per-line interrupt requests to the parent |

## Verification
The bench measures the synchroniser latency exactly. A design with one stage too few or too many would show the pending bit on the wrong edge. It sends an acknowledge on the very edge that a new edge is detected. A design that let the acknowledge win would lose that interrupt. It tries to acknowledge a level interrupt while the pin is still active, which a design that latches level hits would wrongly clear. It also drives the opposite edge in each single-edge mode, where a swapped sense decode would set the pending bit. A second instance with a stride of 5 and three lines checks the field placement and the unused line. A design that hardwired the stride would place every field at the wrong bits there.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Field indices inside the control/status word; fixed by software layout.
  localparam int unsigned FLD_SENSE = 0;
  localparam int unsigned FLD_PEND  = 1;
  localparam int unsigned FLD_ACK   = 2;
  localparam int unsigned FLD_EN    = 3;
  localparam int unsigned FLD_ANY   = 4;
  localparam int unsigned FLD_LVL   = 5;
  localparam int unsigned NUM_FLDS  = 6;

  typedef struct packed {
    logic sense;
    logic en;
    logic any_edge;
    logic lvl_mode;
  } line_cfg_t;

  // Default: active-low level, request disabled.
  localparam line_cfg_t CFG_RESET = '{sense: 1'b0, en: 1'b0, any_edge: 1'b0, lvl_mode: 1'b1};

  typedef enum logic [1:0] {
    TRIG_LEVEL,
    TRIG_ONE_EDGE,
    TRIG_ANY_EDGE
  } trig_t;

  function automatic trig_t trig_of(line_cfg_t c);
    if (c.lvl_mode)      return TRIG_LEVEL;
    else if (c.any_edge) return TRIG_ANY_EDGE;
    else                 return TRIG_ONE_EDGE;
  endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/extirq_line.sv
module extirq_line
  import extirq_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  logic      cfg_we,
  input  line_cfg_t cfg_in,
  input  logic      ack,
  output line_cfg_t cfg_q,
  output logic      pend_q
);

  logic prev_q;
  logic rise;
  logic fall;
  logic hit;
  logic pend_d;

  always_comb begin
    rise = pin_s & ~prev_q;
    fall = ~pin_s & prev_q;
    hit  = 1'b0;
    unique case (trig_of(cfg_q))
      TRIG_LEVEL:    hit = (pin_s == cfg_q.sense);
      TRIG_ONE_EDGE: hit = cfg_q.sense ? fall : rise;
      TRIG_ANY_EDGE: hit = rise | fall;
      default:       hit = 1'b0;
    endcase
    if (trig_of(cfg_q) == TRIG_LEVEL) pend_d = hit;
    else                              pend_d = hit | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LVL;
      pend_q <= 1'b0;
      cfg_q  <= CFG_RESET;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_d;
      if (cfg_we) cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned STRIDE    = 4,
  parameter logic        IDLE_LVL  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_pin,
  input  logic                 reg_wr_en,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  localparam int unsigned OFS_SENSE = FLD_SENSE * STRIDE;
  localparam int unsigned OFS_PEND  = FLD_PEND  * STRIDE;
  localparam int unsigned OFS_ACK   = FLD_ACK   * STRIDE;
  localparam int unsigned OFS_EN    = FLD_EN    * STRIDE;
  localparam int unsigned OFS_ANY   = FLD_ANY   * STRIDE;
  localparam int unsigned OFS_LVL   = FLD_LVL   * STRIDE;

  logic [NUM_LINES-1:0] pin_s;
  logic [NUM_LINES-1:0] pend;
  line_cfg_t            cfg   [NUM_LINES];
  logic                 wdata_unused;

  assign wdata_unused = ^reg_wdata;

  extirq_sync #(
    .WIDTH   (NUM_LINES),
    .RST_VAL (IDLE_LVL)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_pin),
    .q_sync  (pin_s)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    line_cfg_t wcfg;
    logic      ack;

    always_comb begin
      wcfg.sense    = reg_wdata[OFS_SENSE + n];
      wcfg.en       = reg_wdata[OFS_EN + n];
      wcfg.any_edge = reg_wdata[OFS_ANY + n];
      wcfg.lvl_mode = reg_wdata[OFS_LVL + n];
      ack           = reg_wr_en & reg_wdata[OFS_ACK + n];
    end

    extirq_line #(
      .IDLE_LVL (IDLE_LVL)
    ) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_s  (pin_s[n]),
      .cfg_we (reg_wr_en),
      .cfg_in (wcfg),
      .ack    (ack),
      .cfg_q  (cfg[n]),
      .pend_q (pend[n])
    );

    assign irq_out[n] = pend[n] & cfg[n].en;
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      reg_rdata[OFS_SENSE + n] = cfg[n].sense;
      reg_rdata[OFS_PEND + n]  = pend[n];
      reg_rdata[OFS_EN + n]    = cfg[n].en;
      reg_rdata[OFS_ANY + n]   = cfg[n].any_edge;
      reg_rdata[OFS_LVL + n]   = cfg[n].lvl_mode;
    end
  end

endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned STRIDE    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] ext_pin,
  input logic                 reg_wr_en,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [NUM_LINES-1:0] irq_out
);

  localparam int unsigned O_SENSE = 0 * STRIDE;
  localparam int unsigned O_PEND  = 1 * STRIDE;
  localparam int unsigned O_ACK   = 2 * STRIDE;
  localparam int unsigned O_EN    = 3 * STRIDE;
  localparam int unsigned O_ANY   = 4 * STRIDE;
  localparam int unsigned O_LVL   = 5 * STRIDE;

  logic [2:0] warm_q;
  logic       chk_unused;

  assign chk_unused = ^{reg_wdata, reg_rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
  end

  // R1: configuration fields take the written value
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_rdata[O_EN +: NUM_LINES] == $past(reg_wdata[O_EN +: NUM_LINES]))
               && (reg_rdata[O_LVL +: NUM_LINES] == $past(reg_wdata[O_LVL +: NUM_LINES])));

  // R1: configuration holds without a write
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rdata[O_SENSE +: NUM_LINES]) && $stable(reg_rdata[O_ANY +: NUM_LINES])
                && $stable(reg_rdata[O_EN +: NUM_LINES]) && $stable(reg_rdata[O_LVL +: NUM_LINES]));

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
    // R8: no request from a disabled line
    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[n] |-> reg_rdata[O_EN + n] && reg_rdata[O_PEND + n]);

    // R4: edge-mode pending holds until acknowledged
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && !reg_rdata[O_LVL + n] && reg_rdata[O_PEND + n]) |=> reg_rdata[O_PEND + n]);

    // R7: acknowledge with no pin activity clears an edge-mode pending bit
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 3'd5 && $past(reg_wr_en) && $past(reg_wdata[O_ACK + n])
       && !$past(reg_rdata[O_LVL + n])
       && ($past(ext_pin[n], 3) == $past(ext_pin[n], 4)))
      |-> !reg_rdata[O_PEND + n]);
  end

endmodule

bind extirq_ctrl extirq_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .STRIDE    (STRIDE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_pin   (ext_pin),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out)
);

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin = 4'hF;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic [2:0]  pin5 = 3'h7;
  logic        wr5 = 1'b0;
  logic [31:0] wdata5 = '0;
  logic [31:0] rdata5;
  logic [2:0]  irq5;

  int errors = 0;
  int checks = 0;
  logic [3:0] cs = 4'h0, cm = 4'h0, cb = 4'h0, cl = 4'hF;

  always #2 clk = ~clk;

  extirq_ctrl #(.NUM_LINES(4), .STRIDE(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(pin), .reg_wr_en(wr_en),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq));

  extirq_ctrl #(.NUM_LINES(3), .STRIDE(5)) u_dut5 (
    .clk(clk), .rst_n(rst_n), .ext_pin(pin5), .reg_wr_en(wr5),
    .reg_wdata(wdata5), .reg_rdata(rdata5), .irq_out(irq5));

  function automatic logic [31:0] mk(int st, logic [3:0] s, logic [3:0] p,
                                     logic [3:0] m, logic [3:0] b, logic [3:0] l);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[0*st+n] = s[n]; v[1*st+n] = p[n]; v[3*st+n] = m[n];
      v[4*st+n] = b[n]; v[5*st+n] = l[n];
    end
    return v;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [3:0] ack);
    wr_en = 1'b1;
    wdata = mk(4, cs, 4'h0, cm, cb, cl) | (32'(ack) << 8);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic pend(int n);
    return rdata[4+n];
  endfunction

  task automatic t_reset();
    chk(rdata, 32'h00F0_0000, "R2 reset word");
    chk(32'(irq), 0, "R2 reset irq");
    chk(rdata5, 32'h0E00_0000, "R2 reset word stride5");
  endtask

  task automatic t_level_low();
    cm = 4'hF; wr_cfg(4'h0);
    pin[0] = 1'b0; tick(2);
    chk(32'(pend(0)), 0, "R3 not yet on second edge");
    tick(1);
    chk(32'(pend(0)), 1, "R3 active-low on third edge");
    chk(32'(irq[0]), 1, "R8 enabled request");
    wr_cfg(4'h1);
    chk(32'(pend(0)), 1, "R3 ack ignored while active");
    pin[0] = 1'b1; tick(3);
    chk(32'(pend(0)), 0, "R3 level released");
  endtask

  task automatic t_level_high();
    cs[1] = 1'b1; wr_cfg(4'h0); tick(1);
    chk(32'(pend(1)), 1, "R3 active-high with pin high");
    pin[1] = 1'b0; tick(3);
    chk(32'(pend(1)), 0, "R3 active-high pin low");
    pin[1] = 1'b1; tick(3);
  endtask

  task automatic t_rise();
    cl[2] = 1'b0; cs[2] = 1'b0; cb[2] = 1'b0; wr_cfg(4'h0); tick(2);
    chk(32'(pend(2)), 0, "R4 no event on mode change");
    pin[2] = 1'b0; tick(4);
    chk(32'(pend(2)), 0, "R4 falling ignored");
    pin[2] = 1'b1; tick(4);
    chk(32'(pend(2)), 1, "R4 rising sets");
    pin[2] = 1'b0; tick(4);
    chk(32'(pend(2)), 1, "R4 latched after return");
    wr_cfg(4'h0);
    chk(32'(pend(2)), 1, "R7 ack of 0 no effect");
    wr_cfg(4'h4);
    chk(32'(pend(2)), 0, "R7 ack clears");
    chk(32'(rdata[11:8]), 0, "R7 ack field reads 0");
  endtask

  task automatic t_fall();
    cl[3] = 1'b0; cs[3] = 1'b1; wr_cfg(4'h0); tick(2);
    pin[3] = 1'b0; tick(4);
    chk(32'(pend(3)), 1, "R5 falling sets");
    wr_cfg(4'h8);
    chk(32'(pend(3)), 0, "R5 cleared");
    pin[3] = 1'b1; tick(4);
    chk(32'(pend(3)), 0, "R5 rising ignored");
  endtask

  task automatic t_both();
    cl[0] = 1'b0; cb[0] = 1'b1; wr_cfg(4'h0); tick(2);
    chk(32'(pend(0)), 0, "R6 idle");
    pin[0] = 1'b0; tick(4);
    chk(32'(pend(0)), 1, "R6 falling sets");
    wr_cfg(4'h1);
    chk(32'(pend(0)), 0, "R6 cleared");
    pin[0] = 1'b1; tick(4);
    chk(32'(pend(0)), 1, "R6 rising sets");
    wr_cfg(4'h1);
  endtask

  task automatic t_ack_race();
    pin[0] = 1'b0; tick(2);
    wr_cfg(4'h1);
    chk(32'(pend(0)), 1, "R7 new edge beats ack");
    wr_cfg(4'h1);
    chk(32'(pend(0)), 0, "R7 later ack clears");
  endtask

  task automatic t_mask();
    cm[2] = 1'b0; wr_cfg(4'h0);
    pin[2] = 1'b1; tick(4);
    chk(32'(pend(2)), 1, "R8 pending visible while disabled");
    chk(32'(irq[2]), 0, "R8 disabled request low");
    cm[2] = 1'b1; wr_cfg(4'h0);
    chk(32'(irq[2]), 1, "R8 request after enable");
    wr_cfg(4'h4);
  endtask

  task automatic t_ignore();
    wr_en = 1'b1;
    wdata = mk(4, cs, 4'hF, cm, cb, cl) | 32'hFF00_0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk(rdata, mk(4, cs, 4'b0010, cm, cb, cl), "R9 pending write ignored, R1 top bits 0");
  endtask

  task automatic t_stride5();
    wr5 = 1'b1; wdata5 = 32'hFFFF_FFFF;
    @(negedge clk);
    wr5 = 1'b0; tick(1);
    chk(rdata5, 32'h0E73_80E7, "R1 stride5 layout");
    chk(32'(irq5), 32'h7, "R8 stride5 requests");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level_low();
    t_level_high();
    t_rise();
    t_fall();
    t_both();
    t_ack_race();
    t_mask();
    t_ignore();
    t_stride5();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule